// File: doc/BRIEF.md
# Deferred Soft Reset Controller

This block lets software reset the core logic of a network MAC without cutting a bus transfer off partway. Software writes a 1 into a control bit, and that records a request. The controller holds the request until both the receive DMA engine and the transmit DMA engine report idle. It then emits a one-cycle reset pulse to the MAC core. The same control bit reads 1 while the request waits and drops to 0 once the pulse has been issued, so software can poll it to see when the reset has completed.

A second register is read-only. It reports the transmit and receive FIFO cell depths and two identity values, all fixed by parameters. Access goes through a plain 32-bit port with a valid strobe, a write strobe and a word offset. Read data is registered and appears one cycle after the request. The soft reset acts on the MAC core only. The register block itself returns to its initial state only under the global hardware reset.

Top module: `mac_soft_reset_ctrl`

## Requirements
- R1: After global reset (`rstN` low), `coreReset` is 0, `regRdata` is 0, and a read of the reset control word (offset 1) returns 0.
- R2: A read of offset 0 returns the configuration word 0x18440203. Its fields are transmit cell depth in bits 31:24 (0x18), receive cell depth in bits 23:16 (0x44), address type in bits 15:8 (0x02) and configuration value in bits 7:0 (0x03).
- R3: A write to offset 0 is ignored, and later reads of offset 0 still return 0x18440203.
- R4: A write to offset 1 with bit 0 set records a pending request. While the request is pending, a read of offset 1 returns 0x00000001. Bits 31:1 always read 0.
- R5: `coreReset` is high for exactly one cycle. It rises after the first clock edge at which a request is pending and both `rxDmaIdle` and `txDmaIdle` are high. It stays low while either idle input is low.
- R6: The pending bit clears on the same edge that issues the pulse, and reads of offset 1 return 0 from then on.
- R7: A write of 0 to bit 0 of offset 1 has no effect. A write of 1 while a request is already pending does not produce a second pulse.
- R8: A read of any offset other than 0 and 1 returns 0, and writes to such offsets change nothing.
- R9: Read data appears on `regRdata` in the cycle after the read request and holds until the next read.
- R10: The soft reset pulse does not clear the register block. Only the global reset clears a pending request, and it does so without issuing a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Global hardware reset, asynchronous, active low |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regOffset | input | 4 | Word offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| rxDmaIdle | input | 1 | Receive DMA engine is idle |
| txDmaIdle | input | 1 | Transmit DMA engine is idle |
| coreReset | output | 1 | Single-cycle active-high reset to the MAC core |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. Read data follows the edge that samples the read. The pending bit follows the edge that samples the write. `coreReset` follows the first edge at which a request is pending and both idle inputs are high, so a write made while the engines are idle produces its pulse two edges after the write. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares the outputs at the next falling edge against a reference model that advances by the same single edge.

// File: rtl/srst_pkg.sv
package srst_pkg;
  // Strobes the control half hands to the datapath half each cycle.
  typedef struct packed {
    logic rdLoad;   // a read is being accepted this cycle
    logic rdCfg;    // the read targets the configuration word
    logic rdRst;    // the read targets the reset control word
    logic pending;  // current value of the request flag
  } ctrlStrobes_t;
endpackage

// File: rtl/srst_ctrl.sv
module srst_ctrl
  import srst_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int CFG_OFF = 0,
  parameter int RST_OFF = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regOffset,
  input  logic              wBit0,
  input  logic              rxDmaIdle,
  input  logic              txDmaIdle,
  output ctrlStrobes_t      strobes,
  output logic              coreReset
);
  localparam logic [ADDR_W-1:0] CfgSel = CFG_OFF[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] RstSel = RST_OFF[ADDR_W-1:0];

  logic pendingQ;
  logic readReq, hitRst, hitCfg, setReq, applyNow;

  always_comb begin
    hitRst   = (regOffset == RstSel);
    hitCfg   = (regOffset == CfgSel);
    readReq  = regValid && !regWrite;
    setReq   = regValid && regWrite && hitRst && wBit0;
    applyNow = pendingQ && rxDmaIdle && txDmaIdle;
  end

  // Request flag and reset pulse; applying wins over a coincident write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ  <= 1'b0;
      coreReset <= 1'b0;
    end else begin
      coreReset <= applyNow;
      if (applyNow)    pendingQ <= 1'b0;
      else if (setReq) pendingQ <= 1'b1;
    end
  end

  always_comb begin
    strobes.rdLoad  = readReq;
    strobes.rdCfg   = readReq && hitCfg;
    strobes.rdRst   = readReq && hitRst;
    strobes.pending = pendingQ;
  end
endmodule

// File: rtl/srst_datapath.sv
module srst_datapath
  import srst_pkg::*;
#(
  parameter int          FIELD_W   = 8,
  parameter logic [7:0]  TX_DEPTH  = 8'h18,
  parameter logic [7:0]  RX_DEPTH  = 8'h44,
  parameter logic [7:0]  ADDR_TYPE = 8'h02,
  parameter logic [7:0]  CFG_VALUE = 8'h03,
  localparam int         DATA_W    = 4 * FIELD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] regRdata
);
  localparam int NumFields = 4;
  logic [FIELD_W-1:0] fieldVal [NumFields];
  logic [DATA_W-1:0]  cfgWord;
  logic [DATA_W-1:0]  rdNext;

  assign fieldVal[0] = FIELD_W'(CFG_VALUE);
  assign fieldVal[1] = FIELD_W'(ADDR_TYPE);
  assign fieldVal[2] = FIELD_W'(RX_DEPTH);
  assign fieldVal[3] = FIELD_W'(TX_DEPTH);

  // Pack the fields, lowest index in the least significant byte lane.
  for (genvar g = 0; g < NumFields; g++) begin : gPack
    assign cfgWord[g*FIELD_W +: FIELD_W] = fieldVal[g];
  end

  always_comb begin
    rdNext = '0;
    if (strobes.rdCfg)      rdNext = cfgWord;
    else if (strobes.rdRst) rdNext = {{(DATA_W-1){1'b0}}, strobes.pending};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               regRdata <= '0;
    else if (strobes.rdLoad) regRdata <= rdNext;
  end
endmodule

// File: rtl/mac_soft_reset_ctrl.sv
module mac_soft_reset_ctrl
  import srst_pkg::*;
#(
  parameter int         ADDR_W    = 4,
  parameter int         FIELD_W   = 8,
  parameter int         CFG_OFF   = 0,
  parameter int         RST_OFF   = 1,
  parameter logic [7:0] TX_DEPTH  = 8'h18,
  parameter logic [7:0] RX_DEPTH  = 8'h44,
  parameter logic [7:0] ADDR_TYPE = 8'h02,
  parameter logic [7:0] CFG_VALUE = 8'h03,
  localparam int        DATA_W    = 4 * FIELD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regOffset,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              rxDmaIdle,
  input  logic              txDmaIdle,
  output logic              coreReset
);
  ctrlStrobes_t strobes;
  logic         pendingBit;

  assign pendingBit = strobes.pending;

  srst_ctrl #(
    .ADDR_W (ADDR_W),
    .CFG_OFF(CFG_OFF),
    .RST_OFF(RST_OFF)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regValid (regValid),
    .regWrite (regWrite),
    .regOffset(regOffset),
    .wBit0    (regWdata[0]),
    .rxDmaIdle(rxDmaIdle),
    .txDmaIdle(txDmaIdle),
    .strobes  (strobes),
    .coreReset(coreReset)
  );

  srst_datapath #(
    .FIELD_W  (FIELD_W),
    .TX_DEPTH (TX_DEPTH),
    .RX_DEPTH (RX_DEPTH),
    .ADDR_TYPE(ADDR_TYPE),
    .CFG_VALUE(CFG_VALUE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .regRdata(regRdata)
  );
endmodule

// File: rtl/mac_soft_reset_chk.sv
module mac_soft_reset_chk #(
  parameter int          ADDR_W  = 4,
  parameter int          DATA_W  = 32,
  parameter int          CFG_OFF = 0,
  parameter int          RST_OFF = 1,
  parameter logic [31:0] CFG_EXP = 32'h18440203
) (
  input logic              clk,
  input logic              rstN,
  input logic              regValid,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regOffset,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              rxDmaIdle,
  input logic              txDmaIdle,
  input logic              coreReset,
  input logic              pendingBit
);
  localparam logic [ADDR_W-1:0] CfgSel = CFG_OFF[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] RstSel = RST_OFF[ADDR_W-1:0];

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    coreReset |=> !coreReset);

  a_r5_apply_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (pendingBit && rxDmaIdle && txDmaIdle) |=> coreReset);

  a_r5_wait_busy: assert property (@(posedge clk) disable iff (!rstN)
    (pendingBit && !(rxDmaIdle && txDmaIdle)) |=> (!coreReset && pendingBit));

  a_r6_clear_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    coreReset |-> !pendingBit);

  a_r4_set_request: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && regOffset == RstSel && regWdata[0] && !pendingBit) |=> pendingBit);

  a_r7_zero_write_inert: assert property (@(posedge clk) disable iff (!rstN)
    (!pendingBit && !(regValid && regWrite && regOffset == RstSel && regWdata[0])) |=> !pendingBit);

  a_r2_cfg_read: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite && regOffset == CfgSel) |=> (regRdata == DATA_W'(CFG_EXP)));

  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && !regWrite) |=> $stable(regRdata));
endmodule

bind mac_soft_reset_ctrl mac_soft_reset_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CFG_OFF(CFG_OFF),
  .RST_OFF(RST_OFF),
  .CFG_EXP({TX_DEPTH, RX_DEPTH, ADDR_TYPE, CFG_VALUE})
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regValid  (regValid),
  .regWrite  (regWrite),
  .regOffset (regOffset),
  .regWdata  (regWdata),
  .regRdata  (regRdata),
  .rxDmaIdle (rxDmaIdle),
  .txDmaIdle (txDmaIdle),
  .coreReset (coreReset),
  .pendingBit(pendingBit)
);

// File: tb/mac_soft_reset_ctrl_bench.sv
`timescale 1ns/1ps
module mac_soft_reset_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [3:0]  regOffset = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        rxDmaIdle = 1'b0, txDmaIdle = 1'b0;
  logic        coreReset;

  int checks = 0;
  int fails  = 0;

  // Reference state
  logic        mPend  = 1'b0;
  logic [31:0] mRdata = '0;

  always #4 clk = ~clk;

  mac_soft_reset_ctrl u_mac_soft_reset_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regOffset(regOffset), .regWdata(regWdata), .regRdata(regRdata),
    .rxDmaIdle(rxDmaIdle), .txDmaIdle(txDmaIdle), .coreReset(coreReset)
  );

  function automatic logic [31:0] expRead(input logic [3:0] off, input logic pend);
    if (off == 4'd0)      return 32'h18440203;
    else if (off == 4'd1) return {31'b0, pend};
    else                  return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, pass one rising edge, check at the next falling edge.
  task automatic step(input logic v, input logic w, input logic [3:0] off,
                      input logic [31:0] wd, input logic rx, input logic tx,
                      input string tag);
    logic expPulse, nextPend;
    regValid = v; regWrite = w; regOffset = off; regWdata = wd;
    rxDmaIdle = rx; txDmaIdle = tx;
    expPulse = mPend && rx && tx;
    if (expPulse) nextPend = 1'b0;
    else if (v && w && off == 4'd1 && wd[0]) nextPend = 1'b1;
    else nextPend = mPend;
    if (v && !w) mRdata = expRead(off, mPend);
    @(posedge clk);
    @(negedge clk);
    mPend = nextPend;
    check({tag, " coreReset"}, {31'b0, coreReset}, {31'b0, expPulse});
    check({tag, " regRdata"}, regRdata, mRdata);
  endtask

  task automatic doReset();
    rstN = 1'b0; regValid = 1'b0; regWrite = 1'b0;
    repeat (3) @(negedge clk);
    mPend = 1'b0; mRdata = '0;
    check("R1 coreReset in reset", {31'b0, coreReset}, 32'h0);
    check("R1 regRdata in reset", regRdata, 32'h0);
    rstN = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();
    // R1: reset read of control word
    step(1, 0, 4'd1, 0, 0, 0, "R1");
    // R2: configuration word
    step(1, 0, 4'd0, 0, 0, 0, "R2");
    // R3: write to configuration ignored
    step(1, 1, 4'd0, 32'hFFFF_FFFF, 1, 1, "R3");
    step(1, 0, 4'd0, 0, 1, 1, "R3");
    // R8: unmapped offsets
    for (int i = 2; i < 16; i++) begin
      step(1, 1, 4'(i), 32'hFFFF_FFFF, 1, 1, "R8");
      step(1, 0, 4'(i), 0, 1, 1, "R8");
    end
    step(1, 0, 4'd1, 0, 1, 1, "R8");
    // R7: writing 0 does nothing
    step(1, 1, 4'd1, 32'hFFFF_FFFE, 1, 1, "R7");
    step(0, 0, 4'd0, 0, 1, 1, "R7");
    step(1, 0, 4'd1, 0, 1, 1, "R7");
    // R4/R5: request held while busy
    step(1, 1, 4'd1, 32'h1, 0, 0, "R4");
    step(1, 0, 4'd1, 0, 0, 1, "R4");
    step(0, 0, 4'd0, 0, 1, 0, "R5");
    step(1, 1, 4'd1, 32'h1, 0, 1, "R7");
    step(0, 0, 4'd0, 0, 1, 1, "R5");
    step(1, 0, 4'd1, 0, 1, 1, "R6");
    step(0, 0, 4'd0, 0, 1, 1, "R7");
    // R5: request while idle, pulse two edges after write
    step(1, 1, 4'd1, 32'h1, 1, 1, "R5");
    step(0, 0, 4'd0, 0, 1, 1, "R5");
    step(0, 0, 4'd0, 0, 1, 1, "R5");
    step(1, 0, 4'd1, 0, 1, 1, "R6");
    // R9: read data holds between reads
    step(1, 0, 4'd0, 0, 0, 0, "R9");
    step(0, 1, 4'd1, 32'h1, 0, 0, "R9");
    step(0, 0, 4'd2, 0, 0, 0, "R9");
    // R10: global reset clears a pending request without a pulse
    step(1, 1, 4'd1, 32'h1, 0, 0, "R10");
    doReset();
    step(0, 0, 4'd0, 0, 1, 1, "R10");
    step(1, 0, 4'd1, 0, 1, 1, "R10");
    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      logic v, w, rx, tx;
      logic [3:0] off;
      logic [31:0] wd;
      v   = 1'($urandom_range(0, 3) != 0);
      w   = 1'($urandom_range(0, 1));
      off = 4'($urandom_range(0, 3));
      wd  = $urandom();
      rx  = 1'($urandom_range(0, 2) != 0);
      tx  = 1'($urandom_range(0, 2) != 0);
      step(v, w, off, wd, rx, tx, "R5 R9 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule